// File: doc/BRIEF.md
# Dual-Reference Selector with Free-Run Supervision

This block supervises a clock-synchronizing loop that can follow either of two 8 kHz references. It watches a select pin, a force-free-run pin, per-reference loss and out-of-range flags, and a loss-of-lock flag from the phase detector. From these it decides which reference feeds the phase detector and when the loop must run on its own oscillator (free-run). It also drives an active-high alarm and a free-run status output.

Each change of reference opens a qualification window. The window lasts a parameterised number of timebase strobes. While it is open, the loss-of-lock part of the alarm is suppressed, so a clean switch between two good references raises no alarm. The window only counts down while the newly chosen reference is healthy. If both references disappear, the block drops into free-run by itself. A reference that comes back must pass a full window before the status output clears. All outputs are registered and change one clock after the input that causes the change.

Top module: `refsel_supervisor`

## Requirements
- R1: `use_b` shows the reference that drives the phase detector: 0 means A and 1 means B. Outside free-run, it follows a change of `sel_b` one clock later.
- R2: When locked, `alarm` equals the selected reference's loss flag OR its out-of-range flag OR `lock_lost`. This holds for all eight combinations of the three flags.
- R3: While `force_hold` is 1, `holdover` is 1 one clock later. This is true whatever the reference flags are. In this state `alarm` shows only the loss/out-of-range state of the reference named by `sel_b`.
- R4: With `force_hold` at 0 and both loss flags at 1, `holdover` is 1 and `alarm` is 1 one clock later.
- R5: After a switch to a good reference, `lock_lost` is kept out of `alarm` for exactly QUAL_TICKS timebase strobes. On the clock that takes the last strobe, the block is locked to the new reference.
- R6: If the newly selected reference is lost or out of range, `alarm` is 1 one clock after the select change. No strobe counts toward qualification while the reference stays bad.
- R7: Leaving free-run, forced or automatic, always goes through a full qualification window. `holdover` stays 1 until the clock that takes the last strobe of that window.
- R8: Reset (active high, synchronous) gives `alarm`=1, `holdover`=0 and `use_b`=0.
- R9: From reset, `alarm` is held at 1 until `lock_lost` is first seen low. The block is then locked to the reference named by `sel_b`.
- R10: A change of `sel_b` during qualification restarts the window for the new reference. The restart takes priority over a strobe arriving in the same clock.
- R11: `force_hold` takes priority over automatic free-run when both conditions are present at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_b | input | 1 | Reference select: 0 = A, 1 = B |
| force_hold | input | 1 | Force free-run when 1 |
| tick | input | 1 | One-clock timebase strobe for the qualification timer |
| ref_lost | input | 2 | Loss flag per reference (bit 0 = A, bit 1 = B) |
| ref_oor | input | 2 | Out-of-range flag per reference (bit 0 = A, bit 1 = B) |
| lock_lost | input | 1 | Loss-of-lock flag from the phase detector |
| use_b | output | 1 | Registered active reference: 0 = A, 1 = B |
| holdover | output | 1 | Free-run status, 1 while free-running or requalifying after it |
| alarm | output | 1 | Combined reference/lock alarm, active high |

## Verification
Two events can fall in the same clock: the strobe that would close a qualification window, and a new select value. The bench drives both in one cycle, with `lock_lost` held high so that blanking shows at the alarm. It then expects a fresh window of QUAL_TICKS strobes with the alarm still quiet. A second collision is `force_hold` together with both references lost. There the bench expects the forced behaviour, with the alarm tracking only the selected reference.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [2:0] {
    ST_START      = 3'd0,
    ST_LOCK_A     = 3'd1,
    ST_LOCK_B     = 3'd2,
    ST_QUAL       = 3'd3,
    ST_HOLD_AUTO  = 3'd4,
    ST_HOLD_FORCE = 3'd5
  } sup_state_t;
endpackage

// File: rtl/refsel_qual_timer.sv
module refsel_qual_timer #(
  parameter int QUAL_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

  logic [CW-1:0] cnt_q;

  // Window closes on the strobe that completes QUAL_TICKS counts.
  assign done = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: the count never runs past the last strobe of the window
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_b,
  input  logic       force_hold,
  input  logic       lock_lost,
  input  logic [1:0] ref_lost,
  input  logic [1:0] ref_oor,
  input  logic       qual_done,
  output logic       qual_clear,
  output logic       qual_run,
  output logic       use_b,
  output logic       holdover,
  output logic       alarm
);
  sup_state_t state_q, state_nx;
  logic       act_nx, hold_nx, alarm_nx;
  logic [1:0] bad;
  logic       both_lost;

  assign bad       = ref_lost | ref_oor;
  assign both_lost = &ref_lost;
  assign qual_run  = (state_q == ST_QUAL) && !bad[use_b];

  always_comb begin
    state_nx   = state_q;
    act_nx     = use_b;
    qual_clear = 1'b0;
    if (force_hold) begin
      state_nx = ST_HOLD_FORCE;
    end else if (both_lost) begin
      state_nx = ST_HOLD_AUTO;
    end else begin
      unique case (state_q)
        ST_START: begin
          act_nx = sel_b;
          if (!lock_lost) state_nx = sel_b ? ST_LOCK_B : ST_LOCK_A;
        end
        ST_LOCK_A, ST_LOCK_B: begin
          if (sel_b != use_b) begin
            state_nx   = ST_QUAL;
            act_nx     = sel_b;
            qual_clear = 1'b1;
          end
        end
        ST_QUAL: begin
          if (sel_b != use_b) begin
            act_nx     = sel_b;
            qual_clear = 1'b1;
          end else if (qual_done) begin
            state_nx = use_b ? ST_LOCK_B : ST_LOCK_A;
          end
        end
        default: begin
          state_nx   = ST_QUAL;
          act_nx     = sel_b;
          qual_clear = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    hold_nx = (state_nx == ST_HOLD_AUTO) || (state_nx == ST_HOLD_FORCE) ||
              ((state_nx == ST_QUAL) && holdover);
    unique case (state_nx)
      ST_START:      alarm_nx = 1'b1;
      ST_LOCK_A,
      ST_LOCK_B:     alarm_nx = bad[act_nx] | lock_lost;
      ST_QUAL:       alarm_nx = bad[act_nx];
      ST_HOLD_AUTO:  alarm_nx = 1'b1;
      default:       alarm_nx = bad[sel_b];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_START;
      use_b    <= 1'b0;
      holdover <= 1'b0;
      alarm    <= 1'b1;
    end else begin
      state_q  <= state_nx;
      use_b    <= act_nx;
      holdover <= hold_nx;
      alarm    <= alarm_nx;
    end
  end

  p_force_r3: assert property (@(posedge clk) disable iff (rst)
    force_hold |=> (holdover && state_q == ST_HOLD_FORCE));

  p_auto_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!force_hold && both_lost) |=> (holdover && alarm));

  p_lol_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_QUAL && !force_hold && !both_lost && sel_b == use_b &&
     !qual_done && !bad[use_b]) |=> !alarm);

  p_bad_target_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LOCK_A || state_q == ST_LOCK_B) && sel_b != use_b &&
     !force_hold && !both_lost && bad[sel_b]) |=> alarm);

  p_exit_locked_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(holdover) |-> (state_q == ST_LOCK_A || state_q == ST_LOCK_B));

  p_startup_alarm_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START) |-> alarm);
endmodule

// File: rtl/refsel_supervisor.sv
module refsel_supervisor #(
  parameter int QUAL_TICKS = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_b,
  input  logic       force_hold,
  input  logic       tick,
  input  logic [1:0] ref_lost,
  input  logic [1:0] ref_oor,
  input  logic       lock_lost,
  output logic       use_b,
  output logic       holdover,
  output logic       alarm
);
  logic qual_clear, qual_run, qual_done;

  refsel_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (qual_clear),
    .run   (qual_run),
    .tick  (tick),
    .done  (qual_done)
  );

  refsel_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sel_b      (sel_b),
    .force_hold (force_hold),
    .lock_lost  (lock_lost),
    .ref_lost   (ref_lost),
    .ref_oor    (ref_oor),
    .qual_done  (qual_done),
    .qual_clear (qual_clear),
    .qual_run   (qual_run),
    .use_b      (use_b),
    .holdover   (holdover),
    .alarm      (alarm)
  );
endmodule

// File: tb/refsel_supervisor_test.sv
module refsel_supervisor_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst, sel_b, force_hold, tick, lock_lost;
  logic [1:0] ref_lost, ref_oor;
  logic use_b, holdover, alarm;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  refsel_supervisor #(.QUAL_TICKS(Q)) uut (
    .clk(clk), .rst(rst), .sel_b(sel_b), .force_hold(force_hold),
    .tick(tick), .ref_lost(ref_lost), .ref_oor(ref_oor),
    .lock_lost(lock_lost), .use_b(use_b), .holdover(holdover), .alarm(alarm)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  // R2: all eight flag combinations on the active side
  task automatic sweep_locked(input int side);
    for (int c = 0; c < 8; c++) begin
      ref_lost = '0; ref_oor = '0;
      ref_lost[side] = c[0];
      ref_oor[side]  = c[1];
      lock_lost      = c[2];
      step();
      chk("R2 alarm", alarm, c[0] | c[1] | c[2]);
      chk("R2 no holdover", holdover, 1'b0);
      chk("R1 side", use_b, side[0]);
    end
    ref_lost = '0; ref_oor = '0; lock_lost = 1'b0;
    step();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel_b = 1'b0; force_hold = 1'b0; tick = 1'b0;
    lock_lost = 1'b1; ref_lost = '0; ref_oor = '0;
    step(); step();
    chk("R8 alarm", alarm, 1'b1);
    chk("R8 holdover", holdover, 1'b0);
    chk("R8 use_b", use_b, 1'b0);
    rst = 1'b0;

    // R9: startup alarm held until first lock
    step(); step(); step();
    chk("R9 alarm held", alarm, 1'b1);
    lock_lost = 1'b0;
    step();
    chk("R9 lock reached", alarm, 1'b0);

    sweep_locked(0);

    // R5: switch A->B between good references, lock_lost blanked
    lock_lost = 1'b1; sel_b = 1'b1;
    step();
    chk("R1 follows select", use_b, 1'b1);
    chk("R5 blanked", alarm, 1'b0);
    for (int i = 1; i <= Q; i++) begin
      strobes(1);
      chk("R5 window", alarm, (i == Q));
    end
    lock_lost = 1'b0;
    step();
    sweep_locked(1);

    // R10: select flips on the closing strobe -> restart
    lock_lost = 1'b1; sel_b = 1'b0;
    step();
    strobes(Q - 1);
    chk("R10 still blanked", alarm, 1'b0);
    sel_b = 1'b1; tick = 1'b1;
    step();
    tick = 1'b0;
    chk("R10 restart use_b", use_b, 1'b1);
    chk("R10 restart blanked", alarm, 1'b0);
    strobes(Q - 1);
    chk("R10 new window open", alarm, 1'b0);
    strobes(1);
    chk("R10 new window closed", alarm, 1'b1);
    lock_lost = 1'b0;
    step();

    // R6: switch to a bad reference
    lock_lost = 1'b1; ref_oor[0] = 1'b1; sel_b = 1'b0;
    step();
    chk("R6 use_b", use_b, 1'b0);
    chk("R6 alarm at once", alarm, 1'b1);
    strobes(Q + 2);
    chk("R6 alarm stays", alarm, 1'b1);
    ref_oor[0] = 1'b0;
    step();
    chk("R6 not yet qualified", alarm, 1'b0);
    strobes(Q - 1);
    chk("R6 full window open", alarm, 1'b0);
    strobes(1);
    chk("R6 window closed", alarm, 1'b1);
    lock_lost = 1'b0;
    step();
    chk("R2 locked clean", alarm, 1'b0);

    // R3 / R11: forced free-run, with both lost meanwhile
    force_hold = 1'b1;
    step();
    chk("R3 holdover", holdover, 1'b1);
    chk("R3 alarm sel good", alarm, 1'b0);
    ref_lost = 2'b11;
    step();
    chk("R11 forced wins", holdover, 1'b1);
    chk("R11 alarm sel lost", alarm, 1'b1);
    ref_lost = 2'b00;
    step();
    chk("R3 alarm cleared", alarm, 1'b0);
    lock_lost = 1'b1; force_hold = 1'b0;
    step();
    chk("R7 holdover during window", holdover, 1'b1);
    chk("R7 blanked", alarm, 1'b0);
    strobes(Q - 1);
    chk("R7 holdover before last", holdover, 1'b1);
    strobes(1);
    chk("R7 holdover cleared", holdover, 1'b0);
    chk("R7 locked alarm", alarm, 1'b1);
    lock_lost = 1'b0;
    step();

    // R4: automatic free-run and return
    ref_lost = 2'b11;
    step();
    chk("R4 holdover", holdover, 1'b1);
    chk("R4 alarm", alarm, 1'b1);
    strobes(2);
    chk("R4 stays", holdover, 1'b1);
    ref_lost = 2'b01;
    step();
    chk("R7 selected still lost", alarm, 1'b1);
    strobes(Q + 1);
    chk("R7 no qualify while lost", holdover, 1'b1);
    ref_lost = 2'b00;
    step();
    chk("R7 alarm clears", alarm, 1'b0);
    strobes(Q - 1);
    chk("R7 auto window open", holdover, 1'b1);
    strobes(1);
    chk("R7 auto window closed", holdover, 1'b0);

    // R8: reset mid-operation
    sel_b = 1'b1; step();
    rst = 1'b1;
    step();
    chk("R8 alarm again", alarm, 1'b1);
    chk("R8 use_b again", use_b, 1'b0);
    chk("R8 holdover again", holdover, 1'b0);
    rst = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule